// File: doc/BRIEF.md
# Prescaled PWM Generator with Synchronised Register Update

This block produces a single pulse-width modulated output. Its count rate comes from one of three reference tick enables. Each tick is a one-cycle pulse in the system clock domain. A prescaler divides the selected tick stream by a factor of 1, 3, 5 or 6, and then by a power of two from 1 to 128. The result steps a counter that is 6 or 9 bits wide. The output is high while that counter is below a compare value.

Software writes settings one byte at a time into shadow registers. Nothing it writes reaches the running generator until it writes the sync register. At that point all shadow fields move into the active set together. With glitch removal off, the move happens at once. With glitch removal on, it waits until the counter wraps, so a running pulse is never cut short. The output enable is a separate register, and it acts directly without going through the shadow set.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset the output is low. The output enable is off. The active clock code is 0. The counter, the prescaler and every shadow and active field are 0.
- R2: Register 0 bits 1:0 hold the clock code. Codes 1, 2 and 3 select ref_tick bits 0, 1 and 2. Code 0 selects no tick, and the counter then holds its value.
- R3: Register 1 bits 4:3 hold the pre-divider code, where 0, 1, 2 and 3 mean 1, 3, 5 and 6. Bits 2:0 hold the exponent m. The counter advances once every (pre-divider × 2^m) selected ticks.
- R4: Register 0 bit 3 selects the counter size. A 1 gives a 9-bit counter (512 counts per period). A 0 gives a 6-bit counter (64 counts per period). The counter wraps to 0 after its maximum.
- R5: The output is high while the counter is below the active compare value.
  - In 9-bit mode the compare value is register 3 (bits 7:0) with register 4 bit 0 as bit 8.
  - In 6-bit mode only register 3 bits 5:0 are used.
  - A value of 0 keeps the output low. A 6-bit value of 63 gives 63 high counts out of 64.
- R6: Writes to registers 0 to 4 change only the shadow set. They have no effect on the output until a sync.
- R7: Writing register 5 with bit 0 set requests a sync. The request transfers at once in two cases: when shadow glitch-removal (register 2 bit 0) is 0, or when the active clock code is 0. In that case the new settings apply from the next cycle, and the counter and prescaler restart from 0.
- R8: With shadow glitch-removal set and a clock running, a sync request is held pending. The transfer happens on the cycle the counter wraps, so the period in progress completes with the old settings.
- R9: Register 6 bit 0 is the output enable. It is not shadowed and gates the output from the cycle after the write. A sync write with bit 0 clear does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 3 | Reference tick enables, one cycle wide each |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address 0 to 6 |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Modulated output |

## Verification
The output is decoded from registered state only. A register write, sync or enable change at one clock edge is therefore visible on pwm_out one cycle later, and a pending sync shows up on the cycle after the wrap edge. The bench runs a behavioural model that advances on the same edge as the design and compares pwm_out at every falling edge. Each write is therefore checked at exactly the cycle its effect is due, and every later cycle of the period is checked as well. Each stimulus phase tags its comparisons with the requirement it exercises.

// File: rtl/pwm_prescaled.sv
module pwm_prescaled #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int EXP_W  = 3,
  parameter int WIDE_W = 9,
  parameter int NARROW_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int PRE_W   = $clog2(6 * (1 << MAX_EXP) + 1);
  localparam logic [WIDE_W-1:0] WIDE_MAX   = '1;
  localparam logic [WIDE_W-1:0] NARROW_MAX = WIDE_W'((1 << NARROW_W) - 1);
  localparam logic [ADDR_W-1:0] A_SIZECLK = 0, A_DIV = 1, A_TYPE = 2, A_LO = 3,
                                A_HI = 4, A_SYNC = 5, A_EN = 6;

  logic             sh_size, sh_glitch, sh_hi;
  logic [1:0]       sh_clk, sh_div;
  logic [EXP_W-1:0] sh_exp;
  logic [7:0]       sh_lo;
  logic             ac_size, ac_hi;
  logic [1:0]       ac_clk, ac_div;
  logic [EXP_W-1:0] ac_exp;
  logic [7:0]       ac_lo;
  logic             en_q, pend;
  logic [WIDE_W-1:0] cnt;
  logic [PRE_W-1:0]  pre;

  function automatic logic [PRE_W-1:0] div_factor(input logic [1:0] code);
    case (code)
      2'd0: return PRE_W'(1);
      2'd1: return PRE_W'(3);
      2'd2: return PRE_W'(5);
      default: return PRE_W'(6);
    endcase
  endfunction

  wire [PRE_W-1:0]  pre_limit = (div_factor(ac_div) << ac_exp) - PRE_W'(1);
  wire [WIDE_W-1:0] cnt_max   = ac_size ? WIDE_MAX : NARROW_MAX;
  wire [WIDE_W-1:0] cmp_val   = ac_size ? {ac_hi, ac_lo} : WIDE_W'(ac_lo[NARROW_W-1:0]);
  wire tick_sel = (ac_clk != 2'd0) && ref_tick[ac_clk - 2'd1];
  wire step     = tick_sel && (pre == pre_limit);
  wire wrap     = step && (cnt == cnt_max);
  wire wr_hit   = wr_en && (wr_addr <= A_EN);
  wire sync_req = wr_en && (wr_addr == A_SYNC) && wr_data[0];
  wire load     = (sync_req && (!sh_glitch || ac_clk == 2'd0)) || (pend && wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sh_size, sh_glitch, sh_hi, sh_clk, sh_div, sh_exp, sh_lo} <= '0;
      en_q <= 1'b0;
    end else if (wr_hit) begin
      case (wr_addr)
        A_SIZECLK: begin sh_size <= wr_data[3]; sh_clk <= wr_data[1:0]; end
        A_DIV:     begin sh_div <= wr_data[4:3]; sh_exp <= wr_data[EXP_W-1:0]; end
        A_TYPE:    sh_glitch <= wr_data[0];
        A_LO:      sh_lo <= wr_data[7:0];
        A_HI:      sh_hi <= wr_data[0];
        A_EN:      en_q <= wr_data[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ac_size, ac_hi, ac_clk, ac_div, ac_exp, ac_lo} <= '0;
      pend <= 1'b0;
    end else begin
      if (load) begin
        {ac_size, ac_hi, ac_clk, ac_div, ac_exp, ac_lo} <=
          {sh_size, sh_hi, sh_clk, sh_div, sh_exp, sh_lo};
        pend <= 1'b0;
      end else if (sync_req) begin
        pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      cnt <= '0;
      pre <= '0;
    end else if (tick_sel) begin
      if (step) begin
        pre <= '0;
        cnt <= wrap ? '0 : cnt + WIDE_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  assign pwm_out = en_q && (cnt < cmp_val);

  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !pwm_out && cnt == '0);
  a_r2_hold_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_clk == 2'd0 && !load) |=> $stable(cnt));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= cnt_max);
  a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n) pre <= pre_limit);
  a_r8_pending_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> cnt == '0 && pre == '0);
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> !pwm_out);
endmodule

// File: tb/pwm_prescaled_tb.sv
`timescale 1ns/1ps
module pwm_prescaled_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] ref_tick = '0, wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pwm_out;
  int checks = 0, failures = 0, tcount = 0;
  string tag = "R1";

  pwm_prescaled u_dut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
                       .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tcount++;
    ref_tick[2] <= 1'b1;
    ref_tick[1] <= (tcount % 3) == 0;
    ref_tick[0] <= (tcount % 7) == 0;
  end

  int s_size, s_clk, s_div, s_exp, s_gl, s_lo, s_hi;
  int a_size, a_clk, a_div, a_exp, a_lo, a_hi;
  int m_en, m_pend, m_cnt, m_pre;

  function automatic int divmul(int c);
    return (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? 5 : 6;
  endfunction

  function automatic int model_out();
    int v;
    v = a_size ? (a_hi * 256 + a_lo) : (a_lo % 64);
    return (m_en != 0 && m_cnt < v) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s_size = 0; s_clk = 0; s_div = 0; s_exp = 0; s_gl = 0; s_lo = 0; s_hi = 0;
      a_size = 0; a_clk = 0; a_div = 0; a_exp = 0; a_lo = 0; a_hi = 0;
      m_en = 0; m_pend = 0; m_cnt = 0; m_pre = 0;
    end else begin
      int tk, lim, mx, stp, wrp, syn, ld;
      tk  = (a_clk != 0) && ref_tick[a_clk - 1];
      lim = divmul(a_div) * (1 << a_exp) - 1;
      mx  = a_size ? 511 : 63;
      stp = tk && (m_pre == lim);
      wrp = stp && (m_cnt == mx);
      syn = wr_en && wr_addr == 5 && wr_data[0];
      ld  = (syn && (s_gl == 0 || a_clk == 0)) || (m_pend && wrp);
      if (ld) begin
        a_size = s_size; a_clk = s_clk; a_div = s_div; a_exp = s_exp; a_lo = s_lo; a_hi = s_hi;
        m_pend = 0; m_cnt = 0; m_pre = 0;
      end else begin
        if (syn) m_pend = 1;
        if (stp) begin m_pre = 0; m_cnt = wrp ? 0 : m_cnt + 1; end
        else if (tk) m_pre = m_pre + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          0: begin s_size = wr_data[3]; s_clk = wr_data[1:0]; end
          1: begin s_div = wr_data[4:3]; s_exp = wr_data[2:0]; end
          2: s_gl = wr_data[0];
          3: s_lo = wr_data;
          4: s_hi = wr_data[0];
          6: m_en = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (pwm_out !== 1'(model_out())) begin
        failures++;
        if (failures < 20)
          $display("FAIL %s t=%0t pwm_out actual=%0b expected=%0d", tag, $time, pwm_out, model_out());
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run(3);
    @(negedge clk); rst_n = 1'b1;
    checks++;
    if (pwm_out !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset output actual=%0b expected=0", pwm_out);
    end
    tag = "R1"; run(10);
    tag = "R6";
    wr(0, 8'h03); wr(1, 8'h00); wr(3, 20); wr(6, 1); run(60);
    tag = "R7"; wr(5, 1); run(300);
    tag = "R9"; wr(5, 0); run(20);
    tag = "R3"; wr(0, 8'h02); wr(1, 8'h0A); wr(3, 30); wr(5, 1); run(2500);
    tag = "R4"; wr(0, 8'h0B); wr(1, 8'h00); wr(3, 8'h50); wr(4, 1); wr(5, 1); run(1100);
    tag = "R8"; wr(2, 1); wr(3, 100); wr(4, 0); wr(5, 1); run(1100);
    tag = "R5"; wr(0, 8'h03); wr(3, 0); wr(5, 1); run(200);
    wr(3, 8'hFF); wr(5, 1); run(200);
    tag = "R9"; wr(6, 0); run(100); wr(6, 1); run(100);
    tag = "R2"; wr(0, 8'h00); wr(5, 1); run(400);
    wr(0, 8'h01); wr(3, 40); wr(5, 1); run(500);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule